// File: doc/BRIEF.md
# Two-Dimensional Parity Block Checker and Corrector

This block receives one protected block of data row by row and checks it with a two-dimensional parity code. A protected block holds ROWS data rows of COLS bits each. Every row carries one extra bit, its row parity. After the data rows comes one more row that holds the column parities, and its extra bit is the corner parity. The block accumulates a parity check for every row and every column as the rows arrive, including the parity row and the parity column. After the final parity row it classifies the block and, if a single bit is wrong, locates it at the crossing of the one failing row and the one failing column and inverts it.

The corrected data rows then leave through a valid/ready stream, together with a two-bit status code and the row and column index of the repaired bit. The parity sense, even or odd, is chosen per block by the sender and must match the sense the encoder used. While the block streams out, it accepts no new input. For odd parity the corner bit is consistent only when ROWS and COLS have the same evenness; the defaults of 4 and 4 meet this.

Top module: `parity2d_corrector`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: Input row r (r = 0 .. ROWS) carries data column j in bit j and its row parity in bit COLS; row ROWS is the column-parity row. After ROWS+1 accepted rows, out_valid_o is 1 and in_ready_o is 0 in the following cycle; in_ready_o returns to 1 and out_valid_o to 0 the cycle after the last output row is taken.
- R3: A block whose rows and columns all pass gives status 00, both indices 0, and the data rows exactly as received.
- R4: A single flipped data bit at (row i, column j) gives status 01, err_row_o = i, err_col_o = j, and output data equal to the original data.
- R5: A single flipped parity bit is located in the same way (column index COLS for a row parity bit, row index ROWS for a column parity bit, both for the corner), status 01, with the data rows unchanged.
- R6: Two flipped bits give status 10, both indices 0, and the data rows as received.
- R7: Any pattern whose failing checks are not exactly one row and one column, such as three flips in one row, gives status 10 and no correction.
- R8: Four flips at the corners of a rectangle pass every check: status 00 and the corrupted data passes through unchanged.
- R9: in_odd_i is sampled only with row 0 of a block (1 = odd, 0 = even); its value on later rows has no effect. A block checked with the opposite sense from its encoder reports status 10.
- R10: Output rows leave in order 0 .. ROWS-1, out_last_o marks row ROWS-1, a row and the status are held while out_ready_i is 0, and status and indices stay unchanged over all rows of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Block can accept an input row |
| in_row_i | input | COLS+1 | Protected row: data bits and row parity in the top bit |
| in_odd_i | input | 1 | Parity sense for the block, taken with row 0 |
| out_valid_o | output | 1 | Output row valid |
| out_ready_i | input | 1 | Consumer takes the output row |
| out_row_o | output | COLS | Corrected data row |
| out_last_o | output | 1 | Marks the final data row of a block |
| status_o | output | 2 | 00 clean, 01 single error corrected, 10 uncorrectable |
| err_row_o | output | clog2(ROWS+1) | Row of the corrected bit, else 0 |
| err_col_o | output | clog2(COLS+1) | Column of the corrected bit, else 0 |

## Verification
Blocks are tried clean, with one flip in a data bit, in a row parity bit, in a column parity bit and in the corner, with two flips, with three flips in a single row and with four flips on a rectangle; each tells a different outcome of the syndrome decode apart: repair, repair of redundancy only, refusal and silent pass. Both parity senses are used, and a block encoded with one sense but checked with the other separates a correctly latched sense from one taken on the wrong row. Random data with random flip counts and random output stalls checks that the location, the hold under back-pressure and the row order hold beyond the directed cases.

// File: rtl/parity2d_pkg.sv
package parity2d_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } p2d_status_e;

  typedef enum logic {
    PH_RECV = 1'b0,
    PH_SEND = 1'b1
  } p2d_phase_e;
endpackage

// File: rtl/p2d_syndrome.sv
module p2d_syndrome #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_i,
  input  logic                      first_i,
  input  logic [$clog2(ROWS+1)-1:0] idx_i,
  input  logic [COLS:0]             row_i,
  input  logic                      odd_i,
  output logic [ROWS:0]             row_fail_o,
  output logic [COLS:0]             col_fail_o
);
  logic [ROWS:0] row_par_q;
  logic [COLS:0] col_acc_q;
  logic          odd_q;

  // row parity taken per row; column parity folded in the same pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_par_q <= '0;
      col_acc_q <= '0;
      odd_q     <= 1'b0;
    end else if (take_i) begin
      row_par_q[idx_i] <= ^row_i;
      if (first_i) begin
        col_acc_q <= row_i;
        odd_q     <= odd_i;
      end else begin
        col_acc_q <= col_acc_q ^ row_i;
      end
    end
  end

  assign row_fail_o = row_par_q ^ {(ROWS+1){odd_q}};
  assign col_fail_o = col_acc_q ^ {(COLS+1){odd_q}};

  a_r9_sense_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !first_i) |=> $stable(odd_q));
endmodule

// File: rtl/p2d_locate.sv
module p2d_locate
  import parity2d_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS+1),
  localparam int CW = $clog2(COLS+1)
) (
  input  logic [ROWS:0] row_fail_i,
  input  logic [COLS:0] col_fail_i,
  output p2d_status_e   status_o,
  output logic          fix_o,
  output logic [RW-1:0] err_row_o,
  output logic [CW-1:0] err_col_o
);
  logic [RW-1:0] r_pos;
  logic [CW-1:0] c_pos;
  logic [RW-1:0] r_or [ROWS+2];
  logic [CW-1:0] c_or [COLS+2];
  int unsigned   n_row, n_col;

  // position of a set bit; only used when exactly one is set
  assign r_or[0] = '0;
  assign c_or[0] = '0;
  for (genvar i = 0; i <= ROWS; i++) begin : g_rpos
    assign r_or[i+1] = r_or[i] | (row_fail_i[i] ? RW'(i) : '0);
  end
  for (genvar j = 0; j <= COLS; j++) begin : g_cpos
    assign c_or[j+1] = c_or[j] | (col_fail_i[j] ? CW'(j) : '0);
  end
  assign r_pos = r_or[ROWS+1];
  assign c_pos = c_or[COLS+1];

  always_comb begin
    n_row = $countones(row_fail_i);
    n_col = $countones(col_fail_i);
    if (n_row == 0 && n_col == 0)      status_o = ST_CLEAN;
    else if (n_row == 1 && n_col == 1) status_o = ST_FIXED;
    else                               status_o = ST_FATAL;
  end

  assign fix_o     = (status_o == ST_FIXED);
  assign err_row_o = fix_o ? r_pos : '0;
  assign err_col_o = fix_o ? c_pos : '0;

  always_comb begin
    if (fix_o) begin
      a_r4_fix_at_cross: assert (row_fail_i[err_row_o] && col_fail_i[err_col_o]);
    end
  end
endmodule

// File: rtl/p2d_store.sv
module p2d_store #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS+1),
  localparam int CW = $clog2(COLS+1)
) (
  input  logic            clk_i,
  input  logic            wr_i,
  input  logic [RW-1:0]   wr_idx_i,
  input  logic [COLS-1:0] wr_data_i,
  input  logic [RW-1:0]   rd_idx_i,
  input  logic            fix_i,
  input  logic [RW-1:0]   fix_row_i,
  input  logic [CW-1:0]   fix_col_i,
  output logic [COLS-1:0] rd_data_o
);
  logic [COLS-1:0] mem_q [ROWS];
  logic [COLS-1:0] mask;
  logic [COLS-1:0] raw;

  always_ff @(posedge clk_i) begin
    if (wr_i && (wr_idx_i < RW'(ROWS))) mem_q[wr_idx_i[RW-1:0]] <= wr_data_i;
  end

  assign raw = (rd_idx_i < RW'(ROWS)) ? mem_q[rd_idx_i] : '0;

  // a parity-column index (COLS) matches no data bit
  for (genvar j = 0; j < COLS; j++) begin : g_mask
    assign mask[j] = fix_i && (rd_idx_i == fix_row_i) && (fix_col_i == CW'(j));
  end

  assign rd_data_o = raw ^ mask;
endmodule

// File: rtl/parity2d_corrector.sv
module parity2d_corrector
  import parity2d_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS+1),
  localparam int CW = $clog2(COLS+1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [COLS:0]   in_row_i,
  input  logic            in_odd_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [COLS-1:0] out_row_o,
  output logic            out_last_o,
  output logic [1:0]      status_o,
  output logic [RW-1:0]   err_row_o,
  output logic [CW-1:0]   err_col_o
);
  p2d_phase_e    phase_q;
  logic [RW-1:0] wr_idx_q, rd_idx_q;
  logic          take, give, last_in;
  logic [ROWS:0] row_fail;
  logic [COLS:0] col_fail;
  p2d_status_e   status;
  logic          fix;

  assign in_ready_o  = (phase_q == PH_RECV);
  assign out_valid_o = (phase_q == PH_SEND);
  assign take        = in_valid_i && in_ready_o;
  assign give        = out_valid_o && out_ready_i;
  assign last_in     = (wr_idx_q == RW'(ROWS));
  assign out_last_o  = out_valid_o && (rd_idx_q == RW'(ROWS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_RECV;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      if (take) begin
        if (last_in) begin
          wr_idx_q <= '0;
          phase_q  <= PH_SEND;
        end else begin
          wr_idx_q <= wr_idx_q + 1'b1;
        end
      end
      if (give) begin
        if (out_last_o) begin
          rd_idx_q <= '0;
          phase_q  <= PH_RECV;
        end else begin
          rd_idx_q <= rd_idx_q + 1'b1;
        end
      end
    end
  end

  p2d_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .first_i    (wr_idx_q == '0),
    .idx_i      (wr_idx_q),
    .row_i      (in_row_i),
    .odd_i      (in_odd_i),
    .row_fail_o (row_fail),
    .col_fail_o (col_fail)
  );

  p2d_locate #(.ROWS(ROWS), .COLS(COLS)) u_loc (
    .row_fail_i (row_fail),
    .col_fail_i (col_fail),
    .status_o   (status),
    .fix_o      (fix),
    .err_row_o  (err_row_o),
    .err_col_o  (err_col_o)
  );

  p2d_store #(.ROWS(ROWS), .COLS(COLS)) u_mem (
    .clk_i     (clk_i),
    .wr_i      (take),
    .wr_idx_i  (wr_idx_q),
    .wr_data_i (in_row_i[COLS-1:0]),
    .rd_idx_i  (rd_idx_q),
    .fix_i     (fix),
    .fix_row_i (err_row_o),
    .fix_col_i (err_col_o),
    .rd_data_o (out_row_o)
  );

  assign status_o = status;

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  a_r2_send_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && last_in) |=> out_valid_o);
  a_r3_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
  a_r6_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'b01) |-> (err_row_o == '0 && err_col_o == '0));
  a_r10_hold_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_row_o) && $stable(status_o)));
  a_r10_stable_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give && !out_last_o) |=> ($stable(status_o) && $stable(err_row_o) && $stable(err_col_o)));
endmodule

// File: tb/parity2d_corrector_tb.sv
module parity2d_corrector_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int RW = $clog2(ROWS+1);
  localparam int CW = $clog2(COLS+1);

  typedef logic [ROWS:0][COLS:0] mat_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [COLS:0]   in_row_i = '0;
  logic            in_odd_i = 1'b0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b0;
  logic [COLS-1:0] out_row_o;
  logic            out_last_o;
  logic [1:0]      status_o;
  logic [RW-1:0]   err_row_o;
  logic [CW-1:0]   err_col_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  parity2d_corrector #(.ROWS(ROWS), .COLS(COLS)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic mat_t encode(input mat_t raw, input bit odd);
    mat_t m = raw;
    for (int r = 0; r < ROWS; r++) m[r][COLS] = ^m[r][COLS-1:0] ^ odd;
    for (int c = 0; c < COLS; c++) begin
      logic p = odd;
      for (int r = 0; r < ROWS; r++) p ^= m[r][c];
      m[ROWS][c] = p;
    end
    m[ROWS][COLS] = ^m[ROWS][COLS-1:0] ^ odd;
    return m;
  endfunction

  function automatic mat_t flip(input mat_t m, input int r, input int c);
    mat_t x = m;
    x[r][c] = ~x[r][c];
    return x;
  endfunction

  function automatic mat_t rnd_mat();
    mat_t m;
    for (int r = 0; r <= ROWS; r++) m[r] = COLS'($urandom());
    return m;
  endfunction

  // send rx, read back, compare; data expected from clean when status is 01
  task automatic run_block(input mat_t clean, input mat_t rx, input bit odd,
                           input int est, input int er, input int ec, input string req);
    int st0, r0, c0;
    for (int r = 0; r <= ROWS; r++) begin
      while ($urandom_range(0, 3) == 0) begin
        in_valid_i = 1'b0;
        @(negedge clk_i);
      end
      in_valid_i = 1'b1;
      in_row_i   = rx[r];
      in_odd_i   = (r == 0) ? odd : ~odd;  // later rows must not matter (R9)
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    chk(out_valid_o && !in_ready_o, "R2", "valid after last row", {out_valid_o, in_ready_o}, 2'b10);
    for (int r = 0; r < ROWS; r++) begin
      while ($urandom_range(0, 2) == 0) begin
        out_ready_i = 1'b0;
        @(negedge clk_i);
      end
      out_ready_i = 1'b1;
      if (r == 0) begin
        st0 = status_o; r0 = err_row_o; c0 = err_col_o;
        chk(status_o == est, req, "status", status_o, est);
        chk(err_row_o == er && err_col_o == ec, req, "index",
            {err_row_o, 4'h0, err_col_o}, (er << 8) | ec);
      end else begin
        chk(status_o == st0 && err_row_o == r0 && err_col_o == c0, "R10", "status stable",
            status_o, st0);
      end
      chk(out_valid_o, "R10", "row valid", out_valid_o, 1);
      chk(out_last_o == (r == ROWS-1), "R10", "last flag", out_last_o, r == ROWS-1);
      chk(out_row_o == ((est == 1) ? clean[r][COLS-1:0] : rx[r][COLS-1:0]), req, "data row",
          out_row_o, (est == 1) ? clean[r][COLS-1:0] : rx[r][COLS-1:0]);
      @(negedge clk_i);
    end
    out_ready_i = 1'b0;
    chk(in_ready_o && !out_valid_o, "R2", "back to receive", {in_ready_o, out_valid_o}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mat_t c, x;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R1", "reset state", {in_ready_o, out_valid_o}, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R1", "after reset", {in_ready_o, out_valid_o}, 2'b10);

    c = encode(mat_t'({5'h0b, 5'h02, 5'h07, 5'h0c, 5'h00}), 1'b0);
    run_block(c, c, 1'b0, 0, 0, 0, "R3");
    run_block(c, flip(c, 1, 2), 1'b0, 1, 1, 2, "R4");
    run_block(c, flip(c, 2, COLS), 1'b0, 1, 2, COLS, "R5");
    run_block(c, flip(c, ROWS, 1), 1'b0, 1, ROWS, 1, "R5");
    run_block(c, flip(c, ROWS, COLS), 1'b0, 1, ROWS, COLS, "R5");
    run_block(c, flip(flip(c, 0, 0), 3, 3), 1'b0, 2, 0, 0, "R6");
    run_block(c, flip(flip(c, 2, 0), 2, 3), 1'b0, 2, 0, 0, "R6");
    run_block(c, flip(flip(flip(c, 1, 0), 1, 1), 1, 3), 1'b0, 2, 0, 0, "R7");
    run_block(c, flip(flip(flip(flip(c, 0, 1), 0, 3), 2, 1), 2, 3), 1'b0, 0, 0, 0, "R8");
    run_block(c, c, 1'b1, 2, 0, 0, "R9");
    c = encode('0, 1'b1);
    run_block(c, c, 1'b1, 0, 0, 0, "R9");
    run_block(c, flip(c, 3, 0), 1'b1, 1, 3, 0, "R9");
    c = encode('1, 1'b1);
    run_block(c, c, 1'b1, 0, 0, 0, "R9");

    for (int k = 0; k < 40; k++) begin
      bit odd = 1'($urandom());
      int kind = $urandom_range(0, 3);
      int r1 = $urandom_range(0, ROWS), c1 = $urandom_range(0, COLS);
      int r2 = (r1 + $urandom_range(1, ROWS)) % (ROWS+1);
      int c2 = (c1 + $urandom_range(1, COLS)) % (COLS+1);
      c = encode(rnd_mat(), odd);
      case (kind)
        0: run_block(c, c, odd, 0, 0, 0, "R3");
        1: run_block(c, flip(c, r1, c1), odd, 1, r1, c1, "R4");
        2: begin
          x = flip(flip(c, r1, c1), ($urandom_range(0, 1) != 0) ? r1 : r2, c2);
          run_block(c, x, odd, 2, 0, 0, "R6");
        end
        default: begin
          x = flip(flip(flip(flip(c, r1, c1), r1, c2), r2, c1), r2, c2);
          run_block(c, x, odd, 0, 0, 0, "R8");
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule